// File: doc/BRIEF.md
# Positional Cube Operator

This block performs one operation per cycle on product terms of functions with multiple-valued inputs and a binary output. Each term (a cube) is a packed vector with one field per input variable. A field has one bit for each value its variable can take. A set bit means that value is in the literal. A field with every bit set is a don't-care, and a field with no bit set is an empty literal.

A 2-bit opcode picks one of four operations on two cubes A and B:

- intersection;
- union, which gives the smallest cube covering both;
- complement of a single literal field of A;
- a merge test that reports whether A and B can combine into one cube.

With every result the block reports whether the cube is empty and how many minterms it covers. The variable count and the radix of each variable are parameters.

Results are registered. They appear one cycle after an accepted request and hold until the next one, so the block fits inside an iterative minimizer that keeps its own loop control.

Top module: `pcu_cube_alu`

## Requirements
- R1: Field k occupies RADIX[k] bits. It starts at the bit given by the sum of the radices of fields 0..k-1, so field 0 sits at the LSB. Bit j of a field set means value j is included. With the default radices {2,3,4}, field 0 is bits [1:0], field 1 is bits [4:2] and field 2 is bits [8:5].
- R2: Opcode 2'b00 returns the bitwise AND of A and B.
- R3: Opcode 2'b01 returns the bitwise OR of A and B.
- R4: Opcode 2'b10 returns A with only the field selected by field_sel_i inverted. All other fields are copied from A, and B has no effect.
- R5: With opcode 2'b10 and field_sel_i >= NUM_VARS, the result equals A unchanged.
- R6: empty_o is high exactly when at least one field of the result has no bit set.
- R7: size_o equals the product over all fields of the number of set bits in each result field. It is 0 for an empty cube, 1 for a minterm and the product of all radices for the full cube. It never overflows.
- R8: Opcode 2'b11 returns A OR B. merge_ok_o is high exactly when A and B differ in exactly one field. Identical cubes, or cubes that differ in two or more fields, give merge_ok_o low.
- R9: merge_ok_o is low for every opcode other than 2'b11.
- R10: A request taken with valid_i high shows on the outputs after the next rising clock edge, with valid_o high for that one cycle. When valid_i is low, valid_o drops and result_o, empty_o, size_o and merge_ok_o hold their values.
- R11: While rst_ni is low, valid_o, result_o, empty_o, size_o and merge_ok_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Opcode: 00 AND, 01 OR, 10 field complement, 11 merge test |
| field_sel_i | input | SEL_W (2) | Field index for the complement |
| cube_a_i | input | CUBE_W (9) | Cube A |
| cube_b_i | input | CUBE_W (9) | Cube B |
| valid_o | output | 1 | Result strobe |
| result_o | output | CUBE_W (9) | Result cube |
| empty_o | output | 1 | Result has an empty literal |
| size_o | output | SIZE_W (5) | Minterm count of the result |
| merge_ok_o | output | 1 | A and B differ in exactly one field |

## Verification
A fault in one field's logic shows in the very next valid result cycle. It appears as wrong bits in that field of result_o, and it also disturbs size_o and empty_o, because both are derived from the same field.

A wrong field offset shows as a complement landing on the wrong bits. A wrong per-field difference flag shows as merge_ok_o set for identical cubes or for cubes that differ in two fields.

Since every result is compared as soon as it appears, a fault is reported on the first request that exercises it.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_CPL = 2'b10,
    OP_MRG = 2'b11
  } pcu_op_e;
endpackage

// File: rtl/pcu_field_unit.sv
module pcu_field_unit
  import pcu_pkg::*;
#(
  parameter int unsigned W     = 2,
  parameter int unsigned CNT_W = 4
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  pcu_op_e          op_i,
  input  logic             sel_i,
  output logic [W-1:0]     r_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             diff_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  r_o = a_i & b_i;
      OP_CPL:  r_o = sel_i ? ~a_i : a_i;
      default: r_o = a_i | b_i;
    endcase
  end

  always_comb begin
    cnt_o = '0;
    for (int j = 0; j < int'(W); j++) cnt_o = cnt_o + CNT_W'(r_o[j]);
  end

  assign zero_o = ~|r_o;
  assign diff_o = a_i != b_i;

  always_comb begin
    if (op_i == OP_AND) assert ((r_o & ~a_i) == '0) else $error("a_r2_field_subset");
  end
endmodule

// File: rtl/pcu_size_mult.sv
module pcu_size_mult #(
  parameter int unsigned N  = 3,
  parameter int unsigned SW = 5
) (
  input  logic [N*SW-1:0] cnt_i,
  output logic [SW-1:0]   prod_o
);
  logic [SW-1:0] part [N+1];
  assign part[0] = SW'(1);

  // each partial product is bounded by the product of radices, so SW suffices
  for (genvar i = 0; i < int'(N); i++) begin : g_stage
    assign part[i+1] = part[i] * cnt_i[i*SW +: SW];
  end

  assign prod_o = part[N];
endmodule

// File: rtl/pcu_cube_alu.sv
module pcu_cube_alu
  import pcu_pkg::*;
#(
  parameter int unsigned NUM_VARS        = 3,
  parameter int unsigned RADIX[NUM_VARS] = '{2, 3, 4},
  localparam int unsigned SEL_W  = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1,
  localparam int unsigned CUBE_W = sum_upto(NUM_VARS),
  localparam int unsigned PROD   = prod_all(),
  localparam int unsigned SIZE_W = $clog2(PROD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [SEL_W-1:0]  field_sel_i,
  input  logic [CUBE_W-1:0] cube_a_i,
  input  logic [CUBE_W-1:0] cube_b_i,
  output logic              valid_o,
  output logic [CUBE_W-1:0] result_o,
  output logic              empty_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              merge_ok_o
);
  function automatic int unsigned sum_upto(int unsigned k);
    int unsigned s = 0;
    for (int unsigned j = 0; j < k; j++) s += RADIX[j];
    return s;
  endfunction

  function automatic int unsigned prod_all();
    int unsigned p = 1;
    for (int unsigned j = 0; j < NUM_VARS; j++) p *= RADIX[j];
    return p;
  endfunction

  pcu_op_e                  op;
  logic [CUBE_W-1:0]        res_c;
  logic [NUM_VARS*SIZE_W-1:0] cnt_c;
  logic [NUM_VARS-1:0]      zero_c, diff_c;
  logic [SIZE_W-1:0]        size_c;

  assign op = pcu_op_e'(op_i);

  for (genvar i = 0; i < int'(NUM_VARS); i++) begin : g_field
    localparam int unsigned LO = sum_upto(i);
    localparam int unsigned W  = RADIX[i];
    pcu_field_unit #(.W(W), .CNT_W(SIZE_W)) u_field (
      .a_i    (cube_a_i[LO +: W]),
      .b_i    (cube_b_i[LO +: W]),
      .op_i   (op),
      .sel_i  (field_sel_i == SEL_W'(i)),
      .r_o    (res_c[LO +: W]),
      .cnt_o  (cnt_c[i*SIZE_W +: SIZE_W]),
      .zero_o (zero_c[i]),
      .diff_o (diff_c[i])
    );
  end

  pcu_size_mult #(.N(NUM_VARS), .SW(SIZE_W)) u_size (
    .cnt_i  (cnt_c),
    .prod_o (size_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      empty_o    <= 1'b0;
      size_o     <= '0;
      merge_ok_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o   <= res_c;
        empty_o    <= |zero_c;
        size_o     <= size_c;
        merge_ok_o <= (op == OP_MRG) && ($countones(diff_c) == 1);
      end
    end
  end

  a_r6_empty_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (empty_o == (size_o == '0)));
  a_r7_size_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_o <= SIZE_W'(PROD));
  a_r10_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r10_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(size_o) && $stable(merge_ok_o));
  a_r2_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_AND) |=>
      ((result_o & ~$past(cube_a_i)) == '0) && ((result_o & ~$past(cube_b_i)) == '0));
  a_r3_superset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_OR) |=> ((($past(cube_a_i) | $past(cube_b_i)) & ~result_o) == '0));
  a_r9_merge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != OP_MRG) |=> !merge_ok_o);
endmodule

// File: tb/pcu_cube_alu_tb.sv
module pcu_cube_alu_tb;
  localparam int RDX[3] = '{2, 3, 4};
  localparam int OFS[3] = '{0, 2, 5};

  typedef struct {
    logic [8:0] res;
    logic       empty;
    logic [4:0] size;
    logic       mrg;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [1:0] sel_i = '0;
  logic [8:0] a_i = '0, b_i = '0;
  logic       valid_o, empty_o, merge_ok_o;
  logic [8:0] result_o;
  logic [4:0] size_o;

  int   total = 0, bad = 0;
  bit   done = 0;
  exp_t q[$];
  logic [8:0] last_res;

  always #4 clk = ~clk;

  pcu_cube_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .field_sel_i(sel_i), .cube_a_i(a_i), .cube_b_i(b_i),
    .valid_o(valid_o), .result_o(result_o), .empty_o(empty_o),
    .size_o(size_o), .merge_ok_o(merge_ok_o)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic exp_t model(logic [1:0] op, logic [8:0] a, logic [8:0] b, logic [1:0] sel);
    exp_t e;
    int ndiff = 0;
    e.res = '0; e.empty = 1'b0; e.size = 5'd1;
    for (int f = 0; f < 3; f++) begin
      logic [8:0] m, fa, fb, rf;
      m  = (9'd1 << RDX[f]) - 9'd1;
      fa = (a >> OFS[f]) & m;
      fb = (b >> OFS[f]) & m;
      case (op)
        2'b00: rf = fa & fb;
        2'b10: rf = (int'(sel) == f) ? (~fa & m) : fa;
        default: rf = fa | fb;
      endcase
      e.res  = e.res | (rf << OFS[f]);
      e.size = e.size * 5'($countones(rf));
      if (rf == 0) e.empty = 1'b1;
      if (fa != fb) ndiff++;
    end
    e.mrg = (op == 2'b11) && (ndiff == 1);
    case (op)
      2'b00: e.tag = "R2";
      2'b01: e.tag = "R3";
      2'b10: e.tag = (sel >= 2'd3) ? "R5" : "R4";
      default: e.tag = "R8";
    endcase
    return e;
  endfunction

  task automatic drive(logic [1:0] op, logic [8:0] a, logic [8:0] b, logic [1:0] sel, string tag = "");
    exp_t e;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; sel_i = sel; valid_i = 1'b1;
    e = model(op, a, b, sel);
    if (tag != "") e.tag = tag;
    q.push_back(e);
    last_res = e.res;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        chk("R10 unexpected valid", 16'd1, 16'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, 16'(result_o), 16'(e.res));
        chk("R6", 16'(empty_o), 16'(e.empty));
        chk("R7", 16'(size_o), 16'(e.size));
        chk((e.tag == "R8") ? "R8" : "R9", 16'(merge_ok_o), 16'(e.mrg));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid", 16'(valid_o), 16'd0);
    chk("R11 result", 16'(result_o), 16'd0);
    chk("R11 size", 16'(size_o), 16'd0);
    chk("R11 empty", 16'(empty_o), 16'd0);
    chk("R11 merge", 16'(merge_ok_o), 16'd0);
    rst_n = 1'b1;
    idle(2);

    // R1 layout: complement field 1 of an all-zero cube hits bits [4:2]
    drive(2'b10, 9'h000, 9'h1FF, 2'd1, "R1");
    // R7 full cube and minterm
    drive(2'b01, 9'h1FF, 9'h000, 2'd0);
    drive(2'b00, 9'h1FF, 9'b0001_001_01, 2'd0);
    // R2 intersections, one empty
    drive(2'b00, 9'b0110_011_11, 9'b0011_110_01, 2'd0);
    drive(2'b00, 9'b1100_011_11, 9'b0011_110_01, 2'd0);
    // R3 union
    drive(2'b01, 9'b0001_001_01, 9'b0100_100_10, 2'd0);
    // R4 complement each field, R5 out of range
    drive(2'b10, 9'b0101_010_01, 9'h1FF, 2'd0);
    drive(2'b10, 9'b0101_010_01, 9'h000, 2'd2);
    drive(2'b10, 9'b0101_111_01, 9'h000, 2'd1);
    drive(2'b10, 9'b0101_010_01, 9'h1FF, 2'd3);
    // R8 merge cases
    drive(2'b11, 9'b0001_001_01, 9'b0001_010_01, 2'd0);
    drive(2'b11, 9'b0001_001_01, 9'b0001_001_01, 2'd0);
    drive(2'b11, 9'b0001_001_01, 9'b0010_010_01, 2'd0);
    drive(2'b11, 9'b0011_001_01, 9'b0011_001_10, 2'd0);
    // R9 single-field-different cubes under other opcodes
    drive(2'b01, 9'b0001_001_01, 9'b0001_010_01, 2'd0);
    drive(2'b00, 9'b0001_001_01, 9'b0001_011_01, 2'd0);
    // R10 hold while idle
    idle(3);
    chk("R10 idle valid", 16'(valid_o), 16'd0);
    chk("R10 hold result", 16'(result_o), 16'(last_res));
    // mixed patterns
    for (int i = 0; i < 60; i++)
      drive(2'($urandom_range(0, 3)), 9'($urandom), 9'($urandom), 2'($urandom_range(0, 3)));
    idle(3);
    chk("R10 drained", 16'(q.size()), 16'd0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule